// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

This block is a single-clock first-in first-out buffer whose reader can leave a bookmark in the stream and later jump back to it. A pulse on the mark input records the address of the next word the reader would take. A later low level on the active-low rewind input puts the read pointer back on that address, so the words from the bookmark onward come out again, as often as the rewind is repeated.

Once a bookmark exists, the block protects every word from the bookmark onward: the full flag counts occupancy from the bookmark rather than from the live read position. Those words therefore cannot be overwritten while a rewind could still need them. Moving the bookmark forward with a new mark pulse frees the space behind it. Reads take effect only while the synchronous read select is high. The output bus is driven only when that select, registered on the clock, is high and the asynchronous active-low output enable is low. In every other case the data reads as zero with the drive flag low, which stands in for high impedance.

Top module: `fifo_mark_rt`

## Requirements
- R1: After reset, empty is 1, full is 0, rdDrive is 0, both pointers are at zero and no bookmark is recorded.
- R2: A write with wrEn=1 while full=0 stores wrData. A write while full=1 is ignored, and the word is never delivered.
- R3: A read with rdEn=1, rdSel=1 and empty=0 presents the oldest unread word on rdData after the next rising edge and advances the read pointer. With rdSel=0 no read happens.
- R4: A read request while empty=1 is ignored. The read pointer and rdData stay unchanged.
- R5: markIn=1 at a rising edge records, as the bookmark, the address of the word the reader would take on that edge.
- R6: rtN=0 at a rising edge, with a bookmark recorded, reloads the read pointer with the bookmark. Empty is recomputed from the restored pointer after that same edge. A read requested on that edge is suppressed.
- R7: Every rewind after one mark returns to the same bookmark, so repeated rewinds replay the same words in the same order.
- R8: If markIn=1 and rtN=0 on the same edge, the rewind is taken and the bookmark keeps its old value.
- R9: While a bookmark is recorded, full=1 exactly when the number of words written since the bookmark address equals DEPTH, even if those words have all been read.
- R10: rtN=0 before any bookmark has been recorded since reset is ignored.
- R11: rdDrive equals (oeN==0) AND rdSel as sampled on the last rising edge. oeN acts without a clock edge. rdData is zero whenever rdDrive is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| full | output | 1 | No room measured from the protected base |
| rdEn | input | 1 | Read request |
| rdSel | input | 1 | Synchronous read select; gates reads and the output drive |
| markIn | input | 1 | Record the current read address as the bookmark |
| rtN | input | 1 | Active-low rewind to the bookmark |
| oeN | input | 1 | Asynchronous active-low output enable |
| rdData | output | DATA_W | Last word read, zero when not driven |
| rdDrive | output | 1 | High when rdData is actively driven |
| empty | output | 1 | No unread word at the read pointer |

## Verification
The hardest state to reach from the ports is a buffer that reports full while it is also empty: the bookmark sits at the oldest slot, the writer has filled every slot, and the reader has drained them all. A directed sequence marks at address zero, writes DEPTH words, reads them all, then tries one more write and checks that empty stays high. It then moves the bookmark forward and checks that full drops. Seeded random traffic with rare mark and rewind pulses then mixes rewinds with concurrent writes, full stalls and toggles of the select and the output enable.

// File: rtl/fifo_mr_pkg.sv
package fifo_mr_pkg;
  // per-cycle decisions handed from control to datapath
  typedef struct packed {
    logic wrDo;
    logic rdDo;
    logic markDo;
    logic rewindDo;
  } ctrlStrobes_t;
endpackage

// File: rtl/fifo_mr_ctrl.sv
module fifo_mr_ctrl
  import fifo_mr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic         rdSel,
  input  logic         markIn,
  input  logic         rtN,
  input  logic         oeN,
  input  logic         full,
  input  logic         empty,
  input  logic         markValid,
  output ctrlStrobes_t strb,
  output logic         rdDrive
);
  logic selQ;
  logic rewindReq;

  // a rewind needs a bookmark; it overrides both read and mark
  assign rewindReq     = !rtN && markValid;
  assign strb.rewindDo = rewindReq;
  assign strb.markDo   = markIn && !rewindReq;
  assign strb.rdDo     = rdEn && rdSel && !empty && !rewindReq;
  assign strb.wrDo     = wrEn && !full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= rdSel;
  end

  assign rdDrive = !oeN && selQ;

  // R11: the drive flag follows the select sampled on the previous edge
  a_r11_sel_registered: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSel && !oeN) |=> (!rdDrive || !$stable(oeN)));
endmodule

// File: rtl/fifo_mr_dpath.sv
module fifo_mr_dpath
  import fifo_mr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdDrive,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty,
  output logic              markValid
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, markPtr, basePtr, occ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (strb.wrDo) mem[wrPtr[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      markPtr   <= '0;
      markValid <= 1'b0;
      rdQ       <= '0;
    end else begin
      if (strb.wrDo) wrPtr <= wrPtr + 1'b1;
      if (strb.rewindDo)  rdPtr <= markPtr;
      else if (strb.rdDo) rdPtr <= rdPtr + 1'b1;
      if (strb.rdDo) rdQ <= mem[rdPtr[ADDR_W-1:0]];
      if (strb.markDo) begin
        markPtr   <= rdPtr;
        markValid <= 1'b1;
      end
    end
  end

  // protected base: the bookmark once one exists, else the read pointer
  assign basePtr = markValid ? markPtr : rdPtr;
  assign occ     = wrPtr - basePtr;
  assign full    = (occ == DEPTH_P);
  assign empty   = (wrPtr == rdPtr);
  assign rdData  = rdDrive ? rdQ : '0;

  // R9: words from the protected base onward never exceed the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (occ <= DEPTH_P));
  // R4: an empty buffer never sees a read strobe
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strb.rdDo);
  // R6: a rewind lands on the bookmark held on that edge
  a_r6_rewind_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.rewindDo |=> (rdPtr == $past(markPtr)));
  // R8: a rewind leaves the bookmark where it was
  a_r8_mark_kept: assert property (@(posedge clk) disable iff (!rstN)
    strb.rewindDo |=> $stable(markPtr));
  // R2: a full buffer keeps its write pointer
  a_r2_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    full |=> $stable(wrPtr));
endmodule

// File: rtl/fifo_mark_rt.sv
module fifo_mark_rt
  import fifo_mr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              markIn,
  input  logic              rtN,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              empty
);
  ctrlStrobes_t strb;
  logic         markValid;

  fifo_mr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdSel(rdSel),
    .markIn(markIn), .rtN(rtN), .oeN(oeN), .full(full), .empty(empty),
    .markValid(markValid), .strb(strb), .rdDrive(rdDrive)
  );

  fifo_mr_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdDrive(rdDrive),
    .rdData(rdData), .full(full), .empty(empty), .markValid(markValid)
  );

  // R11: an undriven bus reads as zero
  always_comb begin
    if (!rdDrive) a_r11_quiet_bus: assert (rdData == '0);
  end
endmodule

// File: tb/fifo_mark_rt_bench.sv
module fifo_mark_rt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, rdSel = 1'b0, markIn = 1'b0;
  logic rtN = 1'b1, oeN = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic full, empty, rdDrive;

  fifo_mark_rt #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo_mark_rt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .full(full),
    .rdEn(rdEn), .rdSel(rdSel), .markIn(markIn), .rtN(rtN), .oeN(oeN),
    .rdData(rdData), .rdDrive(rdDrive), .empty(empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model
  int mm [DEPTH];
  int mWr, mRd, mMark, mRdQ;
  bit mMarkV, mSel;

  function automatic bit mFull();
    return (mWr - (mMarkV ? mMark : mRd)) == DEPTH;
  endfunction
  function automatic bit mEmpty();
    return mWr == mRd;
  endfunction
  function automatic bit mDrive();
    return !oeN && mSel;
  endfunction

  task automatic chk(string what, int act, int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", curTag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("full", int'(full), int'(mFull()));
    chk("empty", int'(empty), int'(mEmpty()));
    chk("rdDrive", int'(rdDrive), int'(mDrive()));
    chk("rdData", int'(rdData), mDrive() ? mRdQ : 0);
  endtask

  task automatic modelReset();
    mWr = 0; mRd = 0; mMark = 0; mMarkV = 0; mSel = 0; mRdQ = 0;
  endtask

  task automatic step(bit we, int wd, bit re, bit sel, bit mk, bit rt);
    bit rew, wdo, rdo, mdo;
    int oldRd;
    wrEn = we; wrData = DATA_W'(wd); rdEn = re; rdSel = sel;
    markIn = mk; rtN = !rt;
    rew = rt && mMarkV;
    wdo = we && !mFull();
    rdo = re && sel && !mEmpty() && !rew;
    mdo = mk && !rew;
    oldRd = mRd;
    @(posedge clk);
    if (rdo) mRdQ = mm[mRd % DEPTH];
    if (wdo) begin mm[mWr % DEPTH] = wd & 8'hff; mWr++; end
    if (rew) mRd = mMark;
    else if (rdo) mRd++;
    if (mdo) begin mMark = oldRd; mMarkV = 1; end
    mSel = sel;
    @(negedge clk);
    checkAll();
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 0; rdEn = 0; rdSel = 0; markIn = 0; rtN = 1; oeN = 0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    doReset();
    curTag = "R1";
    checkAll();

    // R10: rewind with no bookmark is ignored
    curTag = "R10";
    for (int i = 0; i < 3; i++) step(1, 8'h10 + i, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 0, 1);
    step(0, 0, 1, 1, 0, 0);
    chk("word after ignored rewind", int'(rdData), 8'h11);

    // R2 and R4: fill, overfill, drain, overdrain
    doReset();
    curTag = "R2";
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'h40 + i, 0, 1, 0, 0);
    chk("full after fill", int'(full), 1);
    curTag = "R3";
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 1, 0, 0);
    chk("last word", int'(rdData), 8'h40 + DEPTH - 1);
    curTag = "R4";
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    chk("data held on empty read", int'(rdData), 8'h40 + DEPTH - 1);
    curTag = "R3";
    step(1, 8'h99, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("no read while deselected", int'(empty), 0);

    // R5, R6, R7: mark, read, rewind twice
    doReset();
    curTag = "R5";
    for (int i = 0; i < 6; i++) step(1, 8'h20 + i, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 1, 0);
    chk("marked word read", int'(rdData), 8'h21);
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    curTag = "R6";
    step(0, 0, 1, 1, 0, 1);
    chk("read suppressed on rewind", int'(rdData), 8'h23);
    curTag = "R7";
    for (int k = 0; k < 2; k++) begin
      step(0, 0, 1, 1, 0, 0);
      chk("replay first", int'(rdData), 8'h21);
      step(0, 0, 1, 1, 0, 0);
      step(0, 0, 0, 1, 0, 1);
    end
    // R8: mark and rewind together keep the old bookmark
    curTag = "R8";
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 0, 0);
    chk("bookmark unchanged", int'(rdData), 8'h21);

    // R9: bookmark at zero, full while empty
    doReset();
    curTag = "R9";
    step(0, 0, 0, 1, 1, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 8'h60 + i, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 1, 0, 0);
    chk("full though drained", int'(full), 1);
    step(1, 8'hee, 0, 1, 0, 0);
    chk("write blocked keeps empty", int'(empty), 1);
    step(0, 0, 0, 1, 1, 0);
    chk("full released by new mark", int'(full), 0);

    // R11: asynchronous output enable
    curTag = "R11";
    oeN = 1'b1; #1;
    chk("drive off by oeN", int'(rdDrive), 0);
    chk("bus quiet", int'(rdData), 0);
    oeN = 1'b0; #1;
    chk("drive back", int'(rdDrive), 1);
    step(0, 0, 0, 0, 0, 0);
    chk("drive off by select", int'(rdDrive), 0);

    // random traffic
    doReset();
    curTag = "R3";
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      oeN = ($urandom % 10) == 0;
      step(($urandom % 10) < 6, $urandom % 256, ($urandom % 2) == 1,
           ($urandom % 10) < 8, ($urandom % 25) == 0, ($urandom % 30) == 0);
    end

    finishRun();
  end
endmodule